// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an external SDRAM from power-up to a usable state without software help. Right after reset it captures three configuration words: two bank-group configuration words and one timing word. It then writes them, in order, to the memory controller's registers through a simple register-write port. The first timing write has its two-bit refresh field cleared, so no refresh starts while the device is being initialized.

With the registers loaded, the sequencer emits a NOP command and waits a settling interval of 200 µs. It then issues a fixed list of commands: one precharge, eight auto-refresh commands and one mode-register-set. A minimum gap of 80 ns separates consecutive commands. Every command word in the list carries a mode payload. The payload is either derived from the captured CAS latency and bus width or taken from a nonzero override input. Once the last gap has elapsed, the timing word is written again in full, which starts refresh, and a done flag rises and stays high until the next reset. Both delays are cycle counts derived from a clock-frequency parameter, and a single shared down-counter times them.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, every output is 0. In the first cycle after reset release the port writes the group-0 word (select 0), and in the second cycle it writes the group-1 word (select 1). Both writes come before any command strobe.
- R2: In the third cycle the timing word is written (select 2) with its refresh field, bits 13:12 by default, forced to 0.
- R3: In the fourth cycle a NOP command word 0x01 is strobed. The first list command follows exactly SETTLE_US*CLK_MHZ cycles after the NOP (10000 by default).
- R4: The list is a precharge (code 0x02), then eight auto-refresh commands (code 0x03), then a mode-register-set (code 0x04). Each code is OR-ed with the mode payload. The NOP carries no payload.
- R5: Derived payload: CAS latency is bits 2:0 of the timing word, where the value 2 means CL2 and any other value means CL3. Bit 9 of the group-0 word set to 1 means a 16-bit bus, and 0 means a 32-bit bus. The payload is 0x40 for CL2 with a 32-bit bus, 0x60 for CL3 with a 32-bit bus, 0x20 for CL2 with a 16-bit bus and 0x30 for CL3 with a 16-bit bus.
- R6: A nonzero 8-bit override value replaces the derived payload.
- R7: Consecutive list commands are exactly GAP_CYC cycles apart, where GAP_CYC = ceil(GAP_NS*CLK_MHZ/1000) with a floor of 2 (4 by default). Each command strobe lasts one cycle.
- R8: GAP_CYC cycles after the mode-register-set, the full timing word is written (select 2) and done rises in the same cycle. Done then stays high until reset and no further writes or commands occur.
- R9: The configuration inputs are captured in the first cycle after reset. Later changes to them have no effect on the sequence.
- R10: Asserting reset mid-sequence aborts it, and a release restarts the sequence from the group-0 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp0_cfg_i | input | 32 | Bank-group 0 configuration word |
| grp1_cfg_i | input | 32 | Bank-group 1 configuration word |
| timing_cfg_i | input | 32 | Timing configuration word |
| mode_override_i | input | 8 | Mode payload override, 0 = derive |
| reg_wr_o | output | 1 | Register write strobe |
| reg_sel_o | output | 2 | Register select: 0 group 0, 1 group 1, 2 timing |
| reg_data_o | output | 32 | Register write data |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_word_o | output | 8 | Command code OR-ed with payload |
| done_o | output | 1 | Initialization complete |

## Verification
A stuck or mistaken state register shows at the ports within one cycle. It appears as a write or command strobe in a cycle where none is due, or as a missing strobe where one is due, because the bench compares every cycle against a schedule computed from the parameters. An off-by-one in the shared counter moves the first list command or a gap by one cycle and is caught at that command. A wrong captured configuration or payload selection changes the data of the first write or the precharge word that carries it.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam logic [1:0] SEL_GRP0   = 2'd0;
  localparam logic [1:0] SEL_GRP1   = 2'd1;
  localparam logic [1:0] SEL_TIMING = 2'd2;

  localparam logic [7:0] CODE_NOP = 8'h01;
  localparam logic [7:0] CODE_PRE = 8'h02;
  localparam logic [7:0] CODE_REF = 8'h03;
  localparam logic [7:0] CODE_MRS = 8'h04;

  typedef enum logic [3:0] {
    ST_GRP0, ST_GRP1, ST_TIMING, ST_NOP, ST_SETTLE,
    ST_ISSUE, ST_GAP, ST_FINAL, ST_READY
  } seq_state_e;
endpackage

// File: rtl/init_delay_counter.sv
module init_delay_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load_i)     cnt_q <= load_val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/init_mode_payload.sv
module init_mode_payload #(
  parameter int CL_W = 3
) (
  input  logic [CL_W-1:0] cas_field_i,
  input  logic            narrow_bus_i,
  input  logic [7:0]      override_i,
  output logic [7:0]      payload_o
);
  logic [7:0] base;

  always_comb begin
    base = (cas_field_i == CL_W'(2)) ? 8'h40 : 8'h60;
    if (narrow_bus_i) base = base >> 1;
    payload_o = (override_i != 8'h00) ? override_i : base;
  end
endmodule

// File: rtl/init_cmd_list.sv
module init_cmd_list
  import sdram_init_pkg::*;
#(
  parameter int N_REF = 8,
  parameter int IW    = 4
) (
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    payload_i,
  output logic [7:0]    word_o,
  output logic          last_o
);
  localparam int N_CMD = N_REF + 2;

  logic [7:0] code;

  always_comb begin
    if (idx_i == '0)                 code = CODE_PRE;
    else if (idx_i == IW'(N_CMD-1))  code = CODE_MRS;
    else                             code = CODE_REF;
    word_o = code | payload_i;
    last_o = (idx_i == IW'(N_CMD-1));
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int SETTLE_US = 200,
  parameter int GAP_NS    = 80,
  parameter int N_REF     = 8,
  parameter int REF_LSB   = 12,
  parameter int WIDTH_BIT = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] grp0_cfg_i,
  input  logic [31:0] grp1_cfg_i,
  input  logic [31:0] timing_cfg_i,
  input  logic [7:0]  mode_override_i,
  output logic        reg_wr_o,
  output logic [1:0]  reg_sel_o,
  output logic [31:0] reg_data_o,
  output logic        cmd_valid_o,
  output logic [7:0]  cmd_word_o,
  output logic        done_o
);
  localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
  localparam int GAP_RAW    = (GAP_NS * CLK_MHZ + 999) / 1000;
  localparam int GAP_CYC    = (GAP_RAW < 2) ? 2 : GAP_RAW;
  localparam int MAX_CYC    = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int N_CMD      = N_REF + 2;
  localparam int IW         = $clog2(N_CMD + 1);
  localparam logic [31:0] REF_MASK = 32'h3 << REF_LSB;

  seq_state_e  state_q;
  logic [31:0] g0_q, g1_q, tm_q;
  logic [7:0]  ovr_q;
  logic [IW-1:0] idx_q;
  logic        last_sent_q;

  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_expired;
  logic [7:0]       payload;
  logic [7:0]       list_word;
  logic             list_last;

  init_delay_counter #(.W(CNT_W)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .expired_o  (cnt_expired)
  );

  init_mode_payload #(.CL_W(3)) u_payload (
    .cas_field_i  (tm_q[2:0]),
    .narrow_bus_i (g0_q[WIDTH_BIT]),
    .override_i   (ovr_q),
    .payload_o    (payload)
  );

  init_cmd_list #(.N_REF(N_REF), .IW(IW)) u_list (
    .idx_i     (idx_q),
    .payload_i (payload),
    .word_o    (list_word),
    .last_o    (list_last)
  );

  // Shared counter: loaded for the settle window after the NOP and for
  // the gap after every list command; loaded two short so the next
  // command lands exactly on the interval boundary.
  always_comb begin
    cnt_load = (state_q == ST_NOP) || (state_q == ST_ISSUE);
    cnt_val  = (state_q == ST_NOP) ? CNT_W'(SETTLE_CYC - 2) : CNT_W'(GAP_CYC - 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_GRP0;
      g0_q        <= '0;
      g1_q        <= '0;
      tm_q        <= '0;
      ovr_q       <= '0;
      idx_q       <= '0;
      last_sent_q <= 1'b0;
      reg_wr_o    <= 1'b0;
      reg_sel_o   <= '0;
      reg_data_o  <= '0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      reg_wr_o    <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_word_o  <= '0;
      unique case (state_q)
        ST_GRP0: begin
          g0_q       <= grp0_cfg_i;
          g1_q       <= grp1_cfg_i;
          tm_q       <= timing_cfg_i;
          ovr_q      <= mode_override_i;
          reg_wr_o   <= 1'b1;
          reg_sel_o  <= SEL_GRP0;
          reg_data_o <= grp0_cfg_i;
          state_q    <= ST_GRP1;
        end
        ST_GRP1: begin
          reg_wr_o   <= 1'b1;
          reg_sel_o  <= SEL_GRP1;
          reg_data_o <= g1_q;
          state_q    <= ST_TIMING;
        end
        ST_TIMING: begin
          reg_wr_o   <= 1'b1;
          reg_sel_o  <= SEL_TIMING;
          reg_data_o <= tm_q & ~REF_MASK;
          state_q    <= ST_NOP;
        end
        ST_NOP: begin
          cmd_valid_o <= 1'b1;
          cmd_word_o  <= CODE_NOP;
          state_q     <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (cnt_expired) state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cmd_valid_o <= 1'b1;
          cmd_word_o  <= list_word;
          idx_q       <= idx_q + 1'b1;
          last_sent_q <= list_last;
          state_q     <= ST_GAP;
        end
        ST_GAP: begin
          if (cnt_expired) state_q <= last_sent_q ? ST_FINAL : ST_ISSUE;
        end
        ST_FINAL: begin
          reg_wr_o   <= 1'b1;
          reg_sel_o  <= SEL_TIMING;
          reg_data_o <= tm_q;
          done_o     <= 1'b1;
          state_q    <= ST_READY;
        end
        ST_READY: state_q <= ST_READY;
        default:  state_q <= ST_GRP0;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq_checker.sv
module sdram_init_seq_checker #(
  parameter int CLK_MHZ = 50,
  parameter int GAP_NS  = 80,
  parameter int REF_LSB = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_o,
  input logic [1:0]  reg_sel_o,
  input logic [31:0] reg_data_o,
  input logic        cmd_valid_o,
  input logic        done_o
);
  localparam int GAP_RAW = (GAP_NS * CLK_MHZ + 999) / 1000;
  localparam int GAP_CYC = (GAP_RAW < 2) ? 2 : GAP_RAW;

  logic seen_g0, seen_g1, seen_cmd;
  logic [15:0] since_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_g0   <= 1'b0;
      seen_g1   <= 1'b0;
      seen_cmd  <= 1'b0;
      since_cmd <= '0;
    end else begin
      if (reg_wr_o && reg_sel_o == 2'd0) seen_g0 <= 1'b1;
      if (reg_wr_o && reg_sel_o == 2'd1) seen_g1 <= 1'b1;
      if (cmd_valid_o) begin
        seen_cmd  <= 1'b1;
        since_cmd <= '0;
      end else if (since_cmd != 16'hFFFF) begin
        since_cmd <= since_cmd + 1'b1;
      end
    end
  end

  assert_groups_first_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (seen_g0 && seen_g1));

  assert_refresh_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_o && reg_sel_o == 2'd2 && !done_o) |-> (reg_data_o[REF_LSB +: 2] == 2'b00));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  assert_min_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && seen_cmd) |-> (since_cmd >= 16'(GAP_CYC - 1)));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    $past(done_o) |-> (!cmd_valid_o && !reg_wr_o));

  assert_one_port_busy_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_o, cmd_valid_o}));
endmodule

bind sdram_init_seq sdram_init_seq_checker #(
  .CLK_MHZ (CLK_MHZ),
  .GAP_NS  (GAP_NS),
  .REF_LSB (REF_LSB)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_o    (reg_wr_o),
  .reg_sel_o   (reg_sel_o),
  .reg_data_o  (reg_data_o),
  .cmd_valid_o (cmd_valid_o),
  .done_o      (done_o)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 200 * 50;
  localparam int G   = 4;
  localparam int NL  = 10;
  localparam int FIN = 4 + S + NL * G;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] g0_i = '0, g1_i = '0, tm_i = '0;
  logic [7:0]  ov_i = '0;
  logic        reg_wr_o, cmd_valid_o, done_o;
  logic [1:0]  reg_sel_o;
  logic [31:0] reg_data_o;
  logic [7:0]  cmd_word_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_init_seq u_dut (
    .clk (clk), .rst (rst),
    .grp0_cfg_i (g0_i), .grp1_cfg_i (g1_i), .timing_cfg_i (tm_i),
    .mode_override_i (ov_i),
    .reg_wr_o (reg_wr_o), .reg_sel_o (reg_sel_o), .reg_data_o (reg_data_o),
    .cmd_valid_o (cmd_valid_o), .cmd_word_o (cmd_word_o), .done_o (done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      errors = errors + 1;
      checks = checks + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_payload(logic [31:0] g0, logic [31:0] tm, logic [7:0] ov);
    logic [7:0] p;
    if (ov != 0) return ov;
    p = (tm[2:0] == 3'd2) ? 8'h40 : 8'h60;
    if (g0[9]) p = p >> 1;
    return p;
  endfunction

  task automatic check_idle(input string req);
    checks++;
    if (reg_wr_o || cmd_valid_o || done_o || reg_data_o != 0 || cmd_word_o != 0 || reg_sel_o != 0) begin
      errors++;
      $display("FAIL %s: outputs in reset wr=%0b cv=%0b done=%0b data=%h word=%h expected all 0",
               req, reg_wr_o, cmd_valid_o, done_o, reg_data_o, cmd_word_o);
    end
  endtask

  task automatic run_seq(input logic [31:0] g0, input logic [31:0] g1,
                         input logic [31:0] tm, input logic [7:0] ov,
                         input bit mid_change, input int abort_at);
    logic [7:0] pl;
    int last_cmd;
    pl = exp_payload(g0, tm, ov);
    @(negedge clk);
    rst = 1'b1; g0_i = g0; g1_i = g1; tm_i = tm; ov_i = ov;
    repeat (2) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    last_cmd = -1;
    for (int c = 1; c <= FIN + 3; c++) begin
      logic e_wr, e_cv, e_done;
      logic [1:0] e_sel;
      logic [31:0] e_data;
      logic [7:0] e_word;
      string req;
      @(negedge clk);
      if (abort_at != 0 && c == abort_at) begin
        rst = 1'b1;
        @(negedge clk);
        check_idle("R10");
        return;
      end
      if (mid_change && c == 20) begin
        g0_i = $urandom; g1_i = $urandom; tm_i = $urandom; ov_i = $urandom;
      end
      e_wr = 0; e_cv = 0; e_sel = 0; e_data = 0; e_word = 0; req = "R7";
      e_done = (c >= FIN);
      if (c == 1)      begin e_wr = 1; e_sel = 0; e_data = g0; req = "R1"; end
      else if (c == 2) begin e_wr = 1; e_sel = 1; e_data = g1; req = "R1"; end
      else if (c == 3) begin e_wr = 1; e_sel = 2; e_data = tm & ~32'h3000; req = "R2"; end
      else if (c == 4) begin e_cv = 1; e_word = 8'h01; req = "R3"; end
      else if (c == FIN) begin e_wr = 1; e_sel = 2; e_data = tm; req = "R8"; end
      else if (c > FIN) req = "R8";
      else if (c >= 4 + S && ((c - 4 - S) % G) == 0) begin
        int k;
        k = (c - 4 - S) / G;
        e_cv = 1;
        e_word = ((k == 0) ? 8'h02 : (k == NL - 1) ? 8'h04 : 8'h03) | pl;
        req = (k == 0) ? "R3 R4 R5" : "R4 R5 R7";
      end
      if (mid_change) req = {req, " R9"};
      if (ov != 0) req = {req, " R6"};
      if (e_wr || e_cv || reg_wr_o || cmd_valid_o || c >= FIN || done_o != e_done) begin
        checks++;
        if (reg_wr_o !== e_wr || cmd_valid_o !== e_cv || done_o !== e_done ||
            (e_wr && (reg_sel_o !== e_sel || reg_data_o !== e_data)) ||
            (e_cv && cmd_word_o !== e_word)) begin
          errors++;
          $display("FAIL %s cycle %0d: wr=%0b sel=%0d data=%h cv=%0b word=%h done=%0b expected wr=%0b sel=%0d data=%h cv=%0b word=%h done=%0b",
                   req, c, reg_wr_o, reg_sel_o, reg_data_o, cmd_valid_o, cmd_word_o, done_o,
                   e_wr, e_sel, e_data, e_cv, e_word, e_done);
        end
      end
      if (cmd_valid_o) begin
        if (last_cmd > 4) begin
          checks++;
          if (c - last_cmd != G) begin
            errors++;
            $display("FAIL R7: gap actual %0d expected %0d", c - last_cmd, G);
          end
        end
        last_cmd = c;
      end
      if (c == FIN - G && cmd_valid_o) begin
        checks++;
        if (cmd_word_o !== (8'h04 | pl)) begin
          errors++;
          $display("FAIL %s: mode-set word actual %h expected %h",
                   (ov != 0) ? "R6" : "R5", cmd_word_o, 8'h04 | pl);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R5: all four latency/width combinations
    run_seq(32'h0000_0000, 32'h1111_0000, 32'h0000_3002, 8'h00, 0, 0);
    run_seq(32'h0000_0000, 32'h2222_0000, 32'h0000_3003, 8'h00, 0, 0);
    run_seq(32'h0000_0200, 32'h3333_0200, 32'h0000_1002, 8'h00, 0, 0);
    run_seq(32'h0000_0200, 32'h4444_0200, 32'h0000_2005, 8'h00, 0, 0);
    // R6: override replaces the derived payload
    run_seq(32'h0000_0200, 32'h5555_0000, 32'hFFFF_FFF2, 8'h48, 0, 0);
    // R10: abort mid-settle, then a full random run
    run_seq($urandom, $urandom, $urandom, 8'h00, 0, 50);
    for (int i = 0; i < 2; i++) begin
      logic [7:0] ov;
      ov = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      run_seq($urandom, $urandom, $urandom, ov, 0, 0);
    end
    // R9: inputs change after capture
    run_seq($urandom, $urandom, $urandom, 8'h00, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule